// File: doc/BRIEF.md
# Linked Descriptor Chain Walker

This block walks a chain of job descriptors held in memory and turns each one into records for a cipher or hash datapath. A start pulse gives the address of the first descriptor. The walker reads six words from consecutive word addresses through a word-read port that allows one read in flight. The words are, in order: header, first length, first pointer, second length, second pointer and next-descriptor address. It checks the header parity and emits one job record with the decoded header fields. It then emits address/length segment records: the first buffer or list is tagged as input and the second as output.

A header bit selects how the two pointers are used. In direct mode each pointer addresses its buffer. In linked mode each pointer is the head of a list of three-word link entries (length, data pointer, next-link address). The walker follows each list until the next-link address is zero. It follows the chain until the next-descriptor address is zero and then raises `done`. If it finds a fault it raises `err`, stops, and holds a source code until the next start.

The memory request, the job record and the segment record are valid/ready streams. A record or request, once valid, stays valid with every field unchanged until ready is sampled high at a clock edge. Ready may stay low for any number of cycles. The read response has no back-pressure: the walker accepts it in any cycle it arrives while a read is outstanding. `start`, `busy`, `done`, `err` and `err_code` are plain level or pulse pins.

Top module: `desc_chain_walker`

## Requirements
- R1: A descriptor is six 32-bit words at consecutive word addresses: header, length A, pointer A, length B, pointer B, next address. The walker keeps at most one read outstanding, and it holds a stalled read request and its address stable until accepted. Every read address is word-aligned.
- R2: A header is accepted only if its 32 bits have odd parity (bit 31 is the parity bit). Otherwise the walker stops with code 1 and emits no job record for that descriptor.
- R3: Each accepted descriptor yields one job record before its segments. The fields are: engine = header[30:28], format = header[19:16], direct = header[24], chaining = header[3], encrypt = header[2]. `job_iv_absent` is 1 exactly when format is 8 and both length A and pointer A are zero.
- R4: In direct mode the walker emits buffer A as a segment with dir 0 and then buffer B with dir 1. A buffer whose length is zero is skipped.
- R5: In linked mode the walker emits one segment per link entry, in list order. Entries of list A are tagged dir 0 and all come before those of list B, tagged dir 1. A next-link value of zero ends a list. A list whose descriptor length is zero is never read.
- R6: The walker stops with code 4 if a link entry has zero length, or if the running sum of a list's entry lengths exceeds the descriptor length or ends below it. The check is made before that entry's segment is emitted.
- R7: A zero data pointer in a link entry, or a zero list head in linked mode with a nonzero length, stops the walker with code 5.
- R8: A list head or next-link address with bits [1:0] nonzero stops the walker with code 13. No segment is emitted for the entry that carried that address.
- R9: A start address or next-descriptor address with bits [1:0] nonzero stops the walker with code 12 and issues no read to it.
- R10: A segment whose address[7:0] plus length exceeds 256 stops the walker with code 15 instead of being emitted. A sum of exactly 256 is legal.
- R11: A nonzero next-descriptor address is followed. A zero one ends the walk with `done` high and `busy` low, held until the next start.
- R12: After an error, `err` stays high with `err_code` unchanged and no reads or records are issued until the next start. A start pulse while `busy` is high is ignored.
- R13: A job or segment record held by ready low stays valid with all fields unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a walk when not busy |
| start_addr | input | 32 | Byte address of the first descriptor |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | Last walk ended normally |
| err | output | 1 | Last walk stopped on a fault |
| err_code | output | 4 | Fault source code, valid while err is high |
| mem_req_valid | output | 1 | Word read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| job_valid | output | 1 | Job record valid |
| job_ready | input | 1 | Datapath accepts the job record |
| job_engine | output | 3 | Engine select from header[30:28] |
| job_format | output | 4 | Descriptor format from header[19:16] |
| job_direct | output | 1 | Pointers address buffers directly |
| job_cbc | output | 1 | Chaining mode selected |
| job_enc | output | 1 | Encrypt direction selected |
| job_iv_absent | output | 1 | Key-load descriptor carries no IV |
| seg_valid | output | 1 | Segment record valid |
| seg_ready | input | 1 | Datapath accepts the segment |
| seg_addr | output | 32 | Segment byte address |
| seg_len | output | 32 | Segment length in bytes |
| seg_dir | output | 1 | 0 for input side, 1 for output side |

## Verification
Two things can land in the same cycle. One is a start pulse. The other is a walk that is stalled: a segment or job record held by ready low, or a read waiting for acceptance. The bench provokes this by pulsing start with a misaligned address part way through a slow linked-mode chain, with readies driven randomly. It judges the outcome by the records that follow and by the final status. Every expected record must still arrive in order, the walk must end with done rather than code 12, and the assertions require the stalled record to stay stable through the pulse.

// File: rtl/dcw_pkg.sv
package dcw_pkg;

  typedef enum logic [3:0] {
    ERR_NONE      = 4'd0,
    ERR_PARITY    = 4'd1,
    ERR_LINK_LEN  = 4'd4,
    ERR_LINK_PTR  = 4'd5,
    ERR_DESC_ADDR = 4'd12,
    ERR_LINK_ADDR = 4'd13,
    ERR_BOUNDARY  = 4'd15
  } err_code_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DFETCH, ST_DCHECK, ST_JOB, ST_LIST, ST_LFETCH,
    ST_LCHECK, ST_SCHK, ST_SEG, ST_ADV, ST_NEXT, ST_DONE, ST_FAIL
  } walk_state_e;

  typedef struct packed {
    logic [2:0] engine;
    logic [3:0] format;
    logic       direct;
    logic       cbc;
    logic       enc;
  } hdr_fields_t;

  localparam logic [3:0] FMT_KEY_LOAD = 4'd8;

  function automatic hdr_fields_t decode_hdr(input logic [31:0] h);
    hdr_fields_t f;
    f.engine = h[30:28];
    f.format = h[19:16];
    f.direct = h[24];
    f.cbc    = h[3];
    f.enc    = h[2];
    return f;
  endfunction

endpackage

// File: rtl/dcw_word_fetch.sv
module dcw_word_fetch #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int MAXN = 6,
  localparam int IDX_W = $clog2(MAXN),
  localparam int CNT_W = $clog2(MAXN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [AW-1:0]    base,
  input  logic [CNT_W-1:0] nwords,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [AW-1:0]    mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [DW-1:0]    mem_rsp_data,
  output logic             word_valid,
  output logic [IDX_W-1:0] word_idx,
  output logic [DW-1:0]    word_data,
  output logic             word_last
);
  localparam int STEP = DW / 8;

  logic             active, waiting;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] count;
  logic [AW-1:0]    addr;

  assign mem_req_valid = active & ~waiting;
  assign mem_req_addr  = addr;
  assign word_valid    = active & waiting & mem_rsp_valid;
  assign word_idx      = idx;
  assign word_data     = mem_rsp_data;
  assign word_last     = (CNT_W'(idx) + CNT_W'(1)) == count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      waiting <= 1'b0;
      idx     <= '0;
      count   <= '0;
      addr    <= '0;
    end else if (go) begin
      active  <= 1'b1;
      waiting <= 1'b0;
      idx     <= '0;
      count   <= nwords;
      addr    <= base;
    end else begin
      if (mem_req_valid && mem_req_ready) waiting <= 1'b1;
      if (word_valid) begin
        waiting <= 1'b0;
        idx     <= idx + IDX_W'(1);
        addr    <= addr + AW'(STEP);
        if (word_last) active <= 1'b0;
      end
    end
  end

  // R1
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  // R1
  req_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[1:0] == 2'b00);

endmodule

// File: rtl/dcw_seg_check.sv
module dcw_seg_check #(
  parameter int LW    = 32,
  parameter int BOUND = 256,
  localparam int OFF_W = $clog2(BOUND)
) (
  input  logic [OFF_W-1:0] offset,
  input  logic [LW-1:0]    len,
  output logic             crosses
);
  logic [LW:0] reach;
  assign reach   = {1'b0, len} + (LW + 1)'(offset);
  assign crosses = reach > (LW + 1)'(BOUND);
endmodule

// File: rtl/dcw_link_judge.sv
module dcw_link_judge
  import dcw_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 32
) (
  input  logic [LW-1:0] ent_len,
  input  logic [AW-1:0] ent_ptr,
  input  logic [AW-1:0] ent_next,
  input  logic [LW-1:0] run_sum,
  input  logic [LW-1:0] list_len,
  output logic          bad,
  output err_code_e     code,
  output logic [LW-1:0] sum_after
);
  logic [LW:0] acc;
  assign acc       = {1'b0, run_sum} + {1'b0, ent_len};
  assign sum_after = acc[LW-1:0];

  always_comb begin
    bad  = 1'b1;
    code = ERR_NONE;
    if (ent_len == '0)                                  code = ERR_LINK_LEN;
    else if (ent_ptr == '0)                             code = ERR_LINK_PTR;
    else if (acc > {1'b0, list_len})                    code = ERR_LINK_LEN;
    else if (ent_next == '0 && acc != {1'b0, list_len}) code = ERR_LINK_LEN;
    else if (ent_next[1:0] != 2'b00)                    code = ERR_LINK_ADDR;
    else                                                bad  = 1'b0;
  end
endmodule

// File: rtl/desc_chain_walker.sv
module desc_chain_walker
  import dcw_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LW         = 32,
  parameter int BOUND      = 256,
  parameter int DESC_WORDS = 6,
  parameter int LINK_WORDS = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [3:0]    err_code,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [31:0]   mem_rsp_data,
  output logic          job_valid,
  input  logic          job_ready,
  output logic [2:0]    job_engine,
  output logic [3:0]    job_format,
  output logic          job_direct,
  output logic          job_cbc,
  output logic          job_enc,
  output logic          job_iv_absent,
  output logic          seg_valid,
  input  logic          seg_ready,
  output logic [AW-1:0] seg_addr,
  output logic [LW-1:0] seg_len,
  output logic          seg_dir
);
  localparam int IDX_W = $clog2(DESC_WORDS);
  localparam int CNT_W = $clog2(DESC_WORDS + 1);
  localparam int OFF_W = $clog2(BOUND);

  walk_state_e state;
  err_code_e   err_r;

  logic [31:0]   d_hdr;
  logic [LW-1:0] d_len_a, d_len_b;
  logic [AW-1:0] d_ptr_a, d_ptr_b, d_next;
  logic [LW-1:0] l_len;
  logic [AW-1:0] l_ptr, l_next;
  logic [LW-1:0] run_sum;
  logic [AW-1:0] s_addr;
  logic [LW-1:0] s_len;
  logic          cur_list;

  logic             f_go;
  logic [AW-1:0]    f_base;
  logic [CNT_W-1:0] f_n;
  logic             w_valid, w_last;
  logic [IDX_W-1:0] w_idx;
  logic [31:0]      w_data;

  hdr_fields_t   hf;
  logic [LW-1:0] list_len;
  logic [AW-1:0] list_ptr;
  logic          j_bad, s_cross;
  err_code_e     j_code;
  logic [LW-1:0] j_sum;

  assign hf       = decode_hdr(d_hdr);
  assign list_len = cur_list ? d_len_b : d_len_a;
  assign list_ptr = cur_list ? d_ptr_b : d_ptr_a;

  dcw_word_fetch #(.AW(AW), .DW(32), .MAXN(DESC_WORDS)) u_fetch (
    .clk(clk), .rst_n(rst_n), .go(f_go), .base(f_base), .nwords(f_n),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .word_valid(w_valid), .word_idx(w_idx),
    .word_data(w_data), .word_last(w_last)
  );

  dcw_link_judge #(.AW(AW), .LW(LW)) u_judge (
    .ent_len(l_len), .ent_ptr(l_ptr), .ent_next(l_next), .run_sum(run_sum),
    .list_len(list_len), .bad(j_bad), .code(j_code), .sum_after(j_sum)
  );

  dcw_seg_check #(.LW(LW), .BOUND(BOUND)) u_bound (
    .offset(s_addr[OFF_W-1:0]), .len(s_len), .crosses(s_cross)
  );

  assign busy     = !(state inside {ST_IDLE, ST_DONE, ST_FAIL});
  assign done     = state == ST_DONE;
  assign err      = state == ST_FAIL;
  assign err_code = err_r;

  assign job_valid     = state == ST_JOB;
  assign job_engine    = hf.engine;
  assign job_format    = hf.format;
  assign job_direct    = hf.direct;
  assign job_cbc       = hf.cbc;
  assign job_enc       = hf.enc;
  assign job_iv_absent = (hf.format == FMT_KEY_LOAD) && (d_len_a == '0) && (d_ptr_a == '0);

  assign seg_valid = state == ST_SEG;
  assign seg_addr  = s_addr;
  assign seg_len   = s_len;
  assign seg_dir   = cur_list;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      err_r    <= ERR_NONE;
      d_hdr    <= '0;
      d_len_a  <= '0;
      d_ptr_a  <= '0;
      d_len_b  <= '0;
      d_ptr_b  <= '0;
      d_next   <= '0;
      l_len    <= '0;
      l_ptr    <= '0;
      l_next   <= '0;
      run_sum  <= '0;
      s_addr   <= '0;
      s_len    <= '0;
      cur_list <= 1'b0;
      f_go     <= 1'b0;
      f_base   <= '0;
      f_n      <= '0;
    end else begin
      f_go <= 1'b0;
      unique case (state)
        ST_IDLE, ST_DONE, ST_FAIL: begin
          if (start) begin
            if (start_addr[1:0] != 2'b00) begin
              err_r <= ERR_DESC_ADDR;
              state <= ST_FAIL;
            end else begin
              err_r  <= ERR_NONE;
              f_go   <= 1'b1;
              f_base <= start_addr;
              f_n    <= CNT_W'(DESC_WORDS);
              state  <= ST_DFETCH;
            end
          end
        end
        ST_DFETCH: begin
          if (w_valid) begin
            case (w_idx)
              IDX_W'(0): d_hdr   <= w_data;
              IDX_W'(1): d_len_a <= LW'(w_data);
              IDX_W'(2): d_ptr_a <= AW'(w_data);
              IDX_W'(3): d_len_b <= LW'(w_data);
              IDX_W'(4): d_ptr_b <= AW'(w_data);
              default:   d_next  <= AW'(w_data);
            endcase
            if (w_last) state <= ST_DCHECK;
          end
        end
        ST_DCHECK: begin
          if (^d_hdr == 1'b0) begin
            err_r <= ERR_PARITY;
            state <= ST_FAIL;
          end else begin
            state <= ST_JOB;
          end
        end
        ST_JOB: begin
          if (job_ready) begin
            cur_list <= 1'b0;
            state    <= ST_LIST;
          end
        end
        ST_LIST: begin
          if (list_len == '0) begin
            state <= ST_ADV;
          end else if (hf.direct) begin
            s_addr <= list_ptr;
            s_len  <= list_len;
            state  <= ST_SCHK;
          end else if (list_ptr == '0) begin
            err_r <= ERR_LINK_PTR;
            state <= ST_FAIL;
          end else if (list_ptr[1:0] != 2'b00) begin
            err_r <= ERR_LINK_ADDR;
            state <= ST_FAIL;
          end else begin
            run_sum <= '0;
            f_go    <= 1'b1;
            f_base  <= list_ptr;
            f_n     <= CNT_W'(LINK_WORDS);
            state   <= ST_LFETCH;
          end
        end
        ST_LFETCH: begin
          if (w_valid) begin
            case (w_idx)
              IDX_W'(0): l_len <= LW'(w_data);
              IDX_W'(1): l_ptr <= AW'(w_data);
              default:   l_next <= AW'(w_data);
            endcase
            if (w_last) state <= ST_LCHECK;
          end
        end
        ST_LCHECK: begin
          if (j_bad) begin
            err_r <= j_code;
            state <= ST_FAIL;
          end else begin
            s_addr  <= l_ptr;
            s_len   <= l_len;
            run_sum <= j_sum;
            state   <= ST_SCHK;
          end
        end
        ST_SCHK: begin
          if (s_cross) begin
            err_r <= ERR_BOUNDARY;
            state <= ST_FAIL;
          end else begin
            state <= ST_SEG;
          end
        end
        ST_SEG: begin
          if (seg_ready) begin
            if (hf.direct || l_next == '0) begin
              state <= ST_ADV;
            end else begin
              f_go   <= 1'b1;
              f_base <= l_next;
              f_n    <= CNT_W'(LINK_WORDS);
              state  <= ST_LFETCH;
            end
          end
        end
        ST_ADV: begin
          if (!cur_list) begin
            cur_list <= 1'b1;
            state    <= ST_LIST;
          end else begin
            state <= ST_NEXT;
          end
        end
        ST_NEXT: begin
          if (d_next == '0) begin
            state <= ST_DONE;
          end else if (d_next[1:0] != 2'b00) begin
            err_r <= ERR_DESC_ADDR;
            state <= ST_FAIL;
          end else begin
            f_go   <= 1'b1;
            f_base <= d_next;
            f_n    <= CNT_W'(DESC_WORDS);
            state  <= ST_DFETCH;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R13
  seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && !seg_ready |=> seg_valid && $stable(seg_addr) && $stable(seg_len) && $stable(seg_dir));
  // R13
  job_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    job_valid && !job_ready |=> job_valid && $stable({job_engine, job_format, job_direct, job_cbc, job_enc, job_iv_absent}));
  // R10
  seg_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> ({1'b0, seg_len} + (LW + 1)'(seg_addr[OFF_W-1:0])) <= (LW + 1)'(BOUND));
  // R6
  seg_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> seg_len != '0);
  // R12
  fail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !mem_req_valid && !seg_valid && !job_valid && err_code != 4'd0);
  // R12
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err && !start |=> err && $stable(err_code));
  // R11
  status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy, done, err}));
  // R1
  one_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({seg_valid, job_valid, mem_req_valid}));

endmodule

// File: tb/sim_desc_chain_walker.sv
`timescale 1ns/1ps
module sim_desc_chain_walker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        start = 1'b0;
  logic [31:0] start_addr = '0;
  logic        busy, done, err;
  logic [3:0]  err_code;
  logic        mem_req_valid, mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        job_valid, job_ready = 1'b0;
  logic [2:0]  job_engine;
  logic [3:0]  job_format;
  logic        job_direct, job_cbc, job_enc, job_iv_absent;
  logic        seg_valid, seg_ready = 1'b0;
  logic [31:0] seg_addr, seg_len;
  logic        seg_dir;

  desc_chain_walker u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .busy(busy), .done(done), .err(err), .err_code(err_code),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .job_valid(job_valid), .job_ready(job_ready),
    .job_engine(job_engine), .job_format(job_format), .job_direct(job_direct),
    .job_cbc(job_cbc), .job_enc(job_enc), .job_iv_absent(job_iv_absent),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
    .seg_len(seg_len), .seg_dir(seg_dir)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rd_cnt = 0;
  bit full_rdy = 1'b0;
  bit pend = 1'b0;
  logic [31:0] paddr = '0;
  logic [31:0] mem [0:4095];
  logic [64:0] exp_seg [$];
  logic [9:0]  exp_job [$];
  string tag = "R1";
  logic [31:0] lk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [64:0] act, input logic [64:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Memory, readies and record monitor, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    mem_rsp_valid = 1'b0;
    if (pend) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = mem[paddr[13:2]];
      pend = 1'b0;
    end
    mem_req_ready = full_rdy ? 1'b1 : ($urandom % 3 != 0);
    job_ready     = full_rdy ? 1'b1 : ($urandom % 3 != 0);
    seg_ready     = full_rdy ? 1'b1 : ($urandom % 3 != 0);
    if (mem_req_valid && mem_req_ready) begin
      pend  = 1'b1;
      paddr = mem_req_addr;
      rd_cnt++;
    end
    if (job_valid && job_ready) begin
      logic [9:0] got;
      got = {job_engine, job_format, job_direct, job_cbc, job_enc};
      if (exp_job.size() == 0) chk(1'b0, "R3", "unexpected job", {55'd0, got}, 65'd0);
      else begin
        logic [9:0] e;
        e = exp_job.pop_front();
        chk(got == e, "R3", "job fields", {55'd0, got}, {55'd0, e});
      end
    end
    if (seg_valid && seg_ready) begin
      logic [64:0] g;
      g = {seg_dir, seg_addr, seg_len};
      if (exp_seg.size() == 0) chk(1'b0, tag, "unexpected segment", g, 65'd0);
      else begin
        logic [64:0] e;
        e = exp_seg.pop_front();
        chk(g == e, tag, "segment", g, e);
      end
    end
    if (cyc > 150000) begin
      chk(1'b0, "R11", "watchdog expired", 65'(cyc), 65'd0);
      finish_run();
    end
  end

  function automatic logic [31:0] mkhdr(input logic [2:0] eng, input logic [3:0] fmt,
                                        input bit direct, input bit cbc, input bit enc);
    logic [30:0] b;
    b = '0;
    b[30:28] = eng;
    b[24] = direct;
    b[19:16] = fmt;
    b[3] = cbc;
    b[2] = enc;
    return {~^b, b};
  endfunction

  task automatic put_desc(input logic [31:0] a, input logic [31:0] h,
                          input logic [31:0] la, pa, lb, pb, nx);
    mem[a[13:2]]       = h;
    mem[a[13:2] + 1]   = la;
    mem[a[13:2] + 2]   = pa;
    mem[a[13:2] + 3]   = lb;
    mem[a[13:2] + 4]   = pb;
    mem[a[13:2] + 5]   = nx;
  endtask

  task automatic put_link(input logic [31:0] a, input logic [31:0] l, p, nx);
    mem[a[13:2]]     = l;
    mem[a[13:2] + 1] = p;
    mem[a[13:2] + 2] = nx;
  endtask

  task automatic exp_job_push(input logic [31:0] h);
    exp_job.push_back({h[30:28], h[19:16], h[24], h[3], h[2]});
  endtask

  // random non-crossing buffer
  task automatic rnd_buf(output logic [31:0] p, output logic [31:0] l);
    int off;
    off = $urandom % 200;
    l = 32'(1 + $urandom % (256 - off));
    p = 32'((($urandom % 60) + 1) * 256 + off);
  endtask

  task automatic build_list(input bit dir, input int n, output logic [31:0] head,
                            output logic [31:0] total);
    head = lk;
    total = 0;
    for (int i = 0; i < n; i++) begin
      logic [31:0] cur, p, l, nx;
      cur = lk;
      lk = lk + 16;
      rnd_buf(p, l);
      nx = (i == n - 1) ? 32'd0 : lk;
      put_link(cur, l, p, nx);
      exp_seg.push_back({dir, p, l});
      total = total + l;
    end
  endtask

  task automatic run(input logic [31:0] sa, input logic [3:0] ecode, input string req,
                     input int poke_at);
    int n;
    @(negedge clk);
    start = 1'b1;
    start_addr = sa;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!(done || err) && n < 20000) begin
      @(negedge clk);
      n++;
      if (n == poke_at) begin
        start = 1'b1;
        start_addr = 32'h0000_1003;
        @(negedge clk);
        start = 1'b0;
      end
    end
    if (ecode == 0) chk(done && !err && !busy, req, "walk ends done", {62'd0, busy, done, err}, 65'b010);
    else chk(err && !busy && err_code == ecode, req, "error code",
             {60'd0, err, err_code}, {60'd0, 1'b1, ecode});
    chk(exp_seg.size() == 0 && exp_job.size() == 0, req, "all records seen",
        65'(exp_seg.size() + exp_job.size()), 65'd0);
  endtask

  task automatic quiet_after_err();
    int r0;
    r0 = rd_cnt;
    repeat (20) @(negedge clk);
    // R12: nothing issued and status held while stopped
    chk(rd_cnt == r0 && err && !mem_req_valid && !seg_valid && !job_valid, "R12",
        "quiet after error", 65'(rd_cnt - r0), 65'd0);
  endtask

  initial begin
    logic [31:0] h, p1, l1, p2, l2, hd1, hd2, t1, t2;
    void'($urandom(32'd2718));
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !err && err_code == 0 && !seg_valid && !job_valid && !mem_req_valid,
        "R11", "reset state", {59'd0, busy, done, err, seg_valid, job_valid, mem_req_valid}, 65'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4: key load with no IV, direct
    tag = "R4";
    h = mkhdr(3'd1, 4'd8, 1, 1, 1);
    put_desc(32'h1000, h, 0, 0, 16, 32'h0000_0340, 0);
    exp_job_push(h);
    exp_seg.push_back({1'b1, 32'h340, 32'd16});
    run(32'h1000, 0, "R4", 0);
    // R3: IV absent flag, observed on a fresh single-job run
    full_rdy = 1'b1;
    put_desc(32'h1000, h, 0, 0, 16, 32'h0000_0340, 0);
    exp_job_push(h);
    exp_seg.push_back({1'b1, 32'h340, 32'd16});
    @(negedge clk); start = 1'b1; start_addr = 32'h1000;
    @(negedge clk); start = 1'b0;
    while (!job_valid) @(negedge clk);
    chk(job_iv_absent == 1'b1, "R3", "iv absent", {64'd0, job_iv_absent}, 65'd1);
    while (!done && !err) @(negedge clk);
    put_desc(32'h1000, h, 16, 32'h0000_0530, 16, 32'h0000_0340, 0);
    exp_job_push(h);
    exp_seg.push_back({1'b0, 32'h530, 32'd16});
    exp_seg.push_back({1'b1, 32'h340, 32'd16});
    @(negedge clk); start = 1'b1; start_addr = 32'h1000;
    @(negedge clk); start = 1'b0;
    while (!job_valid) @(negedge clk);
    chk(job_iv_absent == 1'b0, "R3", "iv present", {64'd0, job_iv_absent}, 65'd0);
    while (!done && !err) @(negedge clk);
    full_rdy = 1'b0;

    // R10: exact boundary accepted, one past rejected
    tag = "R10";
    h = mkhdr(3'd1, 4'd5, 1, 0, 1);
    put_desc(32'h1000, h, 16, 32'h0000_03F0, 0, 0, 0);
    exp_job_push(h);
    exp_seg.push_back({1'b0, 32'h3F0, 32'd16});
    run(32'h1000, 0, "R10", 0);
    put_desc(32'h1000, h, 17, 32'h0000_03F0, 0, 0, 0);
    exp_job_push(h);
    run(32'h1000, 15, "R10", 0);
    quiet_after_err();

    // R2: parity fault
    tag = "R2";
    put_desc(32'h1000, h ^ 32'h8000_0000, 16, 32'h400, 0, 0, 0);
    run(32'h1000, 1, "R2", 0);

    // R9: misaligned start issues no read; misaligned next
    tag = "R9";
    begin
      int r0;
      r0 = rd_cnt;
      run(32'h0000_1002, 12, "R9", 0);
      chk(rd_cnt == r0, "R9", "no read on bad start", 65'(rd_cnt - r0), 65'd0);
    end
    put_desc(32'h1000, h, 8, 32'h400, 0, 0, 32'h0000_1026);
    exp_job_push(h);
    exp_seg.push_back({1'b0, 32'h400, 32'd8});
    run(32'h1000, 12, "R9", 0);

    // Linked-mode faults
    h = mkhdr(3'd1, 4'd5, 0, 1, 0);
    tag = "R6";
    put_link(32'h2000, 0, 32'h500, 0);
    put_desc(32'h1000, h, 40, 32'h2000, 0, 0, 0);
    exp_job_push(h);
    run(32'h1000, 4, "R6", 0);
    put_link(32'h2000, 40, 32'h500, 32'h2010);
    put_link(32'h2010, 40, 32'h600, 0);
    put_desc(32'h1000, h, 100, 32'h2000, 0, 0, 0);
    exp_job_push(h);
    exp_seg.push_back({1'b0, 32'h500, 32'd40});
    run(32'h1000, 4, "R6", 0);
    put_link(32'h2000, 60, 32'h500, 32'h2010);
    put_desc(32'h1000, h, 50, 32'h2000, 0, 0, 0);
    exp_job_push(h);
    run(32'h1000, 4, "R6", 0);
    tag = "R7";
    put_link(32'h2000, 40, 32'h0, 0);
    put_desc(32'h1000, h, 40, 32'h2000, 0, 0, 0);
    exp_job_push(h);
    run(32'h1000, 5, "R7", 0);
    put_desc(32'h1000, h, 40, 32'h0, 0, 0, 0);
    exp_job_push(h);
    run(32'h1000, 5, "R7", 0);
    tag = "R8";
    put_desc(32'h1000, h, 40, 32'h2002, 0, 0, 0);
    exp_job_push(h);
    run(32'h1000, 13, "R8", 0);
    put_link(32'h2000, 20, 32'h500, 32'h2011);
    put_desc(32'h1000, h, 40, 32'h2000, 0, 0, 0);
    exp_job_push(h);
    run(32'h1000, 13, "R8", 0);
    quiet_after_err();

    // R12: start while busy is ignored (linked chain, slow readies)
    tag = "R12";
    lk = 32'h2000;
    build_list(1'b0, 3, hd1, t1);
    build_list(1'b1, 3, hd2, t2);
    put_desc(32'h1000, h, t1, hd1, t2, hd2, 32'h1020);
    exp_job_push(h);
    build_list(1'b0, 2, hd1, t1);
    build_list(1'b1, 1, hd2, t2);
    put_desc(32'h1020, h, t1, hd1, t2, hd2, 0);
    exp_job_push(h);
    run(32'h1000, 0, "R12", 8);

    // R5 R11 R1 R4: random chains
    for (int it = 0; it < 25; it++) begin
      int nd;
      nd = 1 + $urandom % 3;
      lk = 32'h2000;
      full_rdy = (it % 5 == 4);
      tag = "R5";
      for (int d = 0; d < nd; d++) begin
        logic [31:0] da, nx;
        int kind;
        da = 32'h1000 + 32'(d * 32);
        nx = (d == nd - 1) ? 32'd0 : da + 32;
        kind = $urandom % 3;
        if (kind == 0) begin
          h = mkhdr(3'd1, 4'd8, 1, 1'($urandom), 1'($urandom));
          rnd_buf(p2, l2);
          if ($urandom % 2 == 0) begin l1 = 0; p1 = 0; end
          else rnd_buf(p1, l1);
          put_desc(da, h, l1, p1, l2, p2, nx);
          exp_job_push(h);
          if (l1 != 0) exp_seg.push_back({1'b0, p1, l1});
          exp_seg.push_back({1'b1, p2, l2});
        end else if (kind == 1) begin
          h = mkhdr(3'(1 + $urandom % 2), 4'd5, 1, 1'($urandom), 1'($urandom));
          rnd_buf(p1, l1);
          rnd_buf(p2, l2);
          put_desc(da, h, l1, p1, l2, p2, nx);
          exp_job_push(h);
          exp_seg.push_back({1'b0, p1, l1});
          exp_seg.push_back({1'b1, p2, l2});
        end else begin
          h = mkhdr(3'd1, 4'd5, 0, 1'($urandom), 1'($urandom));
          exp_job_push(h);
          build_list(1'b0, 1 + $urandom % 3, hd1, t1);
          build_list(1'b1, 1 + $urandom % 3, hd2, t2);
          put_desc(da, h, t1, hd1, t2, hd2, nx);
        end
      end
      run(32'h1000, 0, "R11", 0);
    end

    // R5: zero-length list is skipped without reads
    full_rdy = 1'b0;
    tag = "R5";
    lk = 32'h2000;
    h = mkhdr(3'd2, 4'd5, 0, 0, 0);
    build_list(1'b1, 2, hd2, t2);
    put_desc(32'h1000, h, 0, 32'h2002, t2, hd2, 0);
    exp_job_push(h);
    begin
      int r0;
      r0 = rd_cnt;
      run(32'h1000, 0, "R5", 0);
      chk(rd_cnt - r0 == 12, "R5", "read count, empty list skipped", 65'(rd_cnt - r0), 65'd12);
    end

    finish_run();
  end
endmodule